// File: doc/BRIEF.md
# Strided Pairwise Memory Adder

This block is a sequencer that sits beside a single-port synchronous SRAM and sweeps it in blocks of four words. In each block it reads the word at offset 0 and the word at offset 1. It adds the two words and writes the 16-bit sum into offset 3 of the same block. Offset 2 is never touched. The sweep covers 64 blocks, so it ends with the sum of words 252 and 253 being written to word 255.

A single-cycle pulse on `start` launches a sweep while the block is idle. The block then owns the memory port until the sweep ends. It raises `done` one cycle after the final write. `done` stays high until the next launch or until reset.

The SRAM returns read data one cycle after the address is presented. Every output of the block comes straight from a flip-flop, so each block of four words takes four clock cycles. A full sweep takes 256 cycles after the launch edge.

Top module: `mem_sweep_adder`

## Requirements
- R1: When `start` is high at a clock edge while idle, `mem_addr` shows 0 in the cycle that follows. This is the first operand read.
- R2: For block i the port shows, in consecutive cycles: address 4i (read), address 4i+1 (read), address 4i+1 (data wait), and then address 4i+3 with `mem_we` high. The next cycle starts block i+1 at address 4i+4.
- R3: `mem_we` is high for exactly one cycle per block and is low in every other cycle. A full sweep produces exactly 64 write cycles.
- R4: The word written to 4i+3 equals (M(4i) + M(4i+1)) mod 65536. Any carry out of bit 15 is dropped.
- R5: No address of the form 4i+2 is ever driven on `mem_addr`. Those words keep their contents.
- R6: `mem_addr` never exceeds 255. Words 256 to 1023 are never accessed.
- R7: `done` rises in the cycle after the write to address 255. It first shows 257 cycles after the launch, counted as the cycle that follows the launch edge. It stays high while `start` is low.
- R8: `start` is ignored while a sweep is running. It changes neither the write count nor the time at which the sweep ends.
- R9: A synchronous reset (`rst` high) returns the block to idle. After the next edge `mem_we` and `done` are low, and no further writes happen until a new launch.
- R10: Launching from the done state clears `done` in the cycle after the launch edge and repeats the sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a sweep when the block is idle |
| done | output | 1 | High after the last write, until the next launch or reset |
| mem_addr | output | 10 | SRAM address |
| mem_wdata | output | 16 | SRAM write data (the sum) |
| mem_we | output | 1 | SRAM write enable |
| mem_rdata | input | 16 | SRAM read data, valid one cycle after its address |

## Verification
The bound checker watches the following on every cycle:
- the write strobe never lasting two cycles;
- writes landing only on offset-3 words;
- the skipped offset-2 words and the upper address range never being driven;
- `done` rising only right after the write to word 255 and holding while `start` is low;
- reset clearing the strobe and `done`.

Only the bench's scenarios can show the rest. These are the arithmetic of each stored sum, including wrap-around corner operands, the exact per-block address order, and the total sweep length. They also include the fact that a mid-sweep `start` pulse leaves that length unchanged, and the restart from the done state.

// File: rtl/msa_pkg.sv
package msa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_SUM,
    ST_WR
  } msa_state_t;
endpackage

// File: rtl/msa_addr_gen.sv
module msa_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int GROUPS = 64,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [ADDR_W-1:0] addr_w,
  output logic              last
);
  localparam int CNT_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [CNT_W-1:0]  grp;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk) begin
    if (rst || clr) grp <= '0;
    else if (inc)   grp <= grp + CNT_W'(1);
  end

  assign base   = ADDR_W'(grp) * ADDR_W'(STRIDE);
  assign addr_a = base;
  assign addr_b = base + ADDR_W'(1);
  assign addr_w = base + ADDR_W'(STRIDE - 1);
  assign last   = (grp == CNT_W'(GROUPS - 1));
endmodule

// File: rtl/msa_datapath.sv
module msa_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              capture,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] op_a;

  always_ff @(posedge clk) begin
    if (capture) op_a <= rdata;
  end

  // carry out of the top bit is discarded: result is modulo 2^DATA_W
  assign sum = op_a + rdata;
endmodule

// File: rtl/mem_sweep_adder.sv
module mem_sweep_adder #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int GROUPS = 64,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  import msa_pkg::*;

  msa_state_t        state;
  logic              clr, inc, capture, last;
  logic [ADDR_W-1:0] addr_a, addr_b, addr_w;
  logic [DATA_W-1:0] sum;

  assign clr     = (state == ST_IDLE) && start;
  assign inc     = (state == ST_WR) && !last;
  assign capture = (state == ST_RDB);

  msa_addr_gen #(.ADDR_W(ADDR_W), .GROUPS(GROUPS), .STRIDE(STRIDE)) u_agen (
    .clk(clk), .rst(rst), .clr(clr), .inc(inc),
    .addr_a(addr_a), .addr_b(addr_b), .addr_w(addr_w), .last(last)
  );

  msa_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .capture(capture), .rdata(mem_rdata), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          done     <= 1'b0;
          mem_addr <= '0;
          state    <= ST_RDA;
        end
        ST_RDA: begin
          mem_addr <= addr_b;
          state    <= ST_RDB;
        end
        ST_RDB: state <= ST_SUM;
        ST_SUM: begin
          mem_wdata <= sum;
          mem_addr  <= addr_w;
          mem_we    <= 1'b1;
          state     <= ST_WR;
        end
        ST_WR: begin
          mem_we <= 1'b0;
          if (last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            mem_addr <= addr_w + ADDR_W'(1);
            state    <= ST_RDA;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msa_checker.sv
module msa_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int GROUPS = 64,
  parameter int STRIDE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we
);
  localparam int LAST = (GROUPS - 1) * STRIDE + STRIDE - 1;

  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_wr_offset_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(mem_addr) % STRIDE) == STRIDE - 1);
  assert_skip_word_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(mem_addr) % STRIDE) != STRIDE - 2);
  assert_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(mem_addr) <= LAST);
  assert_done_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(mem_we) && int'($past(mem_addr)) == LAST));
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!mem_we && !done));
endmodule

bind mem_sweep_adder msa_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GROUPS(GROUPS), .STRIDE(STRIDE)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/tb_mem_sweep_adder.sv
module tb_mem_sweep_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        done, mem_we;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [1024];

  int checks = 0, errors = 0, wr_cnt = 0, order_err = 0, bad_acc = 0;
  int cyc;
  logic [9:0] tr_addr [8];
  logic       tr_we   [8];
  logic       tr_done [8];

  // group, operand a, operand b, expected sum
  localparam logic [53:0] VEC [8] = '{
    {6'd0,  16'h0000, 16'h0000, 16'h0000},
    {6'd1,  16'hFFFF, 16'h0001, 16'h0000},
    {6'd17, 16'h8000, 16'h8000, 16'h0000},
    {6'd30, 16'hFFFF, 16'hFFFF, 16'hFFFE},
    {6'd31, 16'h1234, 16'hEDCB, 16'hFFFF},
    {6'd40, 16'hABCD, 16'h1111, 16'hBCDE},
    {6'd62, 16'h7FFF, 16'h0001, 16'h8000},
    {6'd63, 16'h0001, 16'h0002, 16'h0003}
  };

  always #4 clk = ~clk;

  mem_sweep_adder dut (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst) wr_cnt = 0;
    else begin
      if (mem_we) begin
        if (mem_addr != 10'((wr_cnt % 64) * 4 + 3)) order_err++;
        wr_cnt++;
      end
      if (mem_addr[1:0] == 2'd2 || mem_addr >= 10'd256) bad_acc++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fill(input int a);
    return 16'(a * 40503 + 4660);
  endfunction

  task automatic preload();
    for (int a = 0; a < 1024; a++) mem[a] = fill(a);
    for (int v = 0; v < 8; v++) begin
      mem[VEC[v][53:48]*4]     = VEC[v][47:32];
      mem[VEC[v][53:48]*4 + 1] = VEC[v][31:16];
    end
  endtask

  task automatic run(input bit poke);
    @(negedge clk) start = 1'b1;
    cyc = 0;
    while (!done || cyc == 0) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 100);
      if (cyc < 8) begin
        tr_addr[cyc] = mem_addr; tr_we[cyc] = mem_we; tr_done[cyc] = done;
      end
      if (cyc > 2000) break;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(!mem_we && !done, "R9 reset state", {mem_we, done}, 0);
    preload();

    run(1'b0);
    check(tr_addr[1] == 10'd0 && !tr_we[1], "R1 first address", tr_addr[1], 0);
    check(tr_addr[2] == 10'd1 && tr_addr[3] == 10'd1 && !tr_we[2] && !tr_we[3],
          "R2 second read", tr_addr[3], 1);
    check(tr_addr[4] == 10'd3 && tr_we[4], "R2 write slot", tr_addr[4], 3);
    check(tr_addr[5] == 10'd4 && !tr_we[5], "R2 next group", tr_addr[5], 4);
    check(cyc == 257, "R7 done timing", cyc, 257);
    check(wr_cnt == 64, "R3 write count", wr_cnt, 64);
    check(order_err == 0, "R2 write order", order_err, 0);
    for (int v = 0; v < 8; v++)
      check(mem[VEC[v][53:48]*4 + 3] == VEC[v][15:0], "R4 corner sum",
            mem[VEC[v][53:48]*4 + 3], VEC[v][15:0]);
    begin
      int bad = 0, skip_bad = 0;
      for (int g = 0; g < 64; g++) begin
        if (mem[g*4+3] != 16'(mem[g*4] + mem[g*4+1])) bad++;
        if (mem[g*4+2] != fill(g*4+2)) skip_bad++;
      end
      check(bad == 0, "R4 all sums", bad, 0);
      check(skip_bad == 0, "R5 skipped words intact", skip_bad, 0);
    end
    check(bad_acc == 0, "R5 R6 address range", bad_acc, 0);
    repeat (5) @(negedge clk);
    check(done && !mem_we, "R7 done holds", done, 1);

    preload();
    run(1'b1);
    check(tr_done[1] == 1'b0, "R10 done cleared", tr_done[1], 0);
    check(cyc == 257, "R8 timing with start pulse", cyc, 257);
    check(wr_cnt == 128 && order_err == 0, "R8 write count", wr_cnt, 128);

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(!mem_we && !done, "R9 reset mid-sweep", {mem_we, done}, 0);
    repeat (20) @(negedge clk);
    check(wr_cnt == 0 && !done, "R9 idle after reset", wr_cnt, 0);
    check(bad_acc == 0, "R6 no stray access", bad_acc, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule